// File: doc/BRIEF.md
# Carrier-clocked load-modulation line encoder

This block drives the load-modulation control line of a simulated full-duplex tag. It is clocked directly by the reader's RF carrier after that carrier has been squared up into a digital clock. All bit timing is counted in received carrier cycles, so the output stays locked to whatever carrier frequency the reader actually uses. A 64-bit word, presented on a parallel input, is captured into an internal shift register and sent repeatedly for as long as the carrier is present.

Two line codes are available through a mode input: Manchester, where every bit has a forced mid-bit transition, and biphase, where every bit boundary has a transition and a zero bit adds one in the middle. A test mode, enabled by its own input and steered by a 64-bit mask, makes chosen bits one carrier cycle longer. Downstream tooling uses these longer bits to exercise the reader's bit-timing tolerance. The analog switch, the carrier detector and the data store all sit outside this block.

Top module: `carrier_manchester_tx`

## Requirements
- R1: After reset, and on every carrier cycle that follows a cycle with `carrier_ok` low, `mod_out` is 0.
- R2: An unstretched bit lasts exactly 64 carrier cycles. Its first level is held for 32 cycles and its second level for 32 cycles, and the next bit follows immediately with no gap.
- R3: When `code_sel` is 0 (Manchester), the first half of a bit carries the bit value and the second half carries its complement.
- R4: When `code_sel` is 1 (biphase), the line toggles at every bit boundary. It toggles again after 32 cycles only when the bit is 0; a 1 bit holds one level for the whole bit.
- R5: Bits go out MSB first: bit k of a word is `tx_word[63-k]`. After bit 63, sending restarts with `tx_word[63]`. `tx_word` is sampled only when a transmission starts and at each word wrap, so a change in the middle of a word first appears in the next word.
- R6: The first bit begins on the first carrier edge at which `carrier_ok` is sampled high. Its first level is the bit value in Manchester mode and 1 in biphase mode.
- R7: When `carrier_ok` is sampled low, the line returns to 0 on that edge, even in the middle of a bit. The next transmission starts again from `tx_word[63]` with fresh bit timing.
- R8: When `stretch_test` is 1, the bit carrying `tx_word[j]` lasts 65 cycles if `stretch_mask[j]` is 1. The extra cycle lengthens the second half to 33 cycles.
- R9: When `stretch_test` is 0, `stretch_mask` has no effect and every bit lasts 64 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| carrier_clk | input | 1 | Squared reader carrier, used as the clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| carrier_ok | input | 1 | Carrier present; high enables transmission |
| code_sel | input | 1 | Line code: 0 Manchester, 1 biphase |
| tx_word | input | 64 | Data word, sent MSB first and repeated |
| stretch_mask | input | 64 | Per-bit stretch selection, indexed like `tx_word` |
| stretch_test | input | 1 | Enables the one-cycle bit stretch test mode |
| mod_out | output | 1 | Load-modulation control line |

## Verification
The hardest situation to reach is a word wrap that happens while other conditions are also in play. The wrap is the only moment the word input is re-sampled, and a stretched bit can sit just before it. A stretch shifts every later boundary by one cycle, so a small error there surfaces only many bits later. The stimulus therefore runs each transmission past the 64-bit wrap. It also changes the word input ten bits into the first word, so the bench can tell a correct reload from one that samples the input too early. The stretch masks include the bit just before the wrap, and a carrier loss in the middle of a bit is followed by a fresh start to show that the timing resets.

// File: rtl/lm_enc_pkg.sv
package lm_enc_pkg;

   typedef enum logic {
      LC_MANCHESTER = 1'b0,
      LC_BIPHASE    = 1'b1
   } line_code_e;

   // Level driven at the start of a bit (at the boundary).
   function automatic logic bound_level(line_code_e code, logic bit_val, logic prev);
      return (code == LC_MANCHESTER) ? bit_val : ~prev;
   endfunction

   // Level driven at the middle of a bit.
   function automatic logic mid_level(line_code_e code, logic bit_val, logic prev);
      if (code == LC_MANCHESTER) return ~prev;
      return bit_val ? prev : ~prev;
   endfunction

endpackage

// File: rtl/lm_bit_timer.sv
module lm_bit_timer #(
   parameter int BIT_CYCLES = 64,
   localparam int CW = $clog2(BIT_CYCLES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          stretch_req,
   output logic          active,
   output logic          mid_evt,
   output logic          end_evt,
   output logic [CW-1:0] cnt
);

   localparam int HALF = BIT_CYCLES / 2;
   localparam logic [CW-1:0] MID_AT  = CW'(HALF - 1);
   localparam logic [CW-1:0] LAST_AT = CW'(BIT_CYCLES - 1);
   localparam logic [CW-1:0] FULL_AT = CW'(BIT_CYCLES);

   initial begin
      assert (BIT_CYCLES >= 4 && (BIT_CYCLES % 2) == 0)
         else $error("lm_bit_timer: BIT_CYCLES must be even and at least 4");
   end

   logic [CW-1:0] cnt_q;
   logic          act_q;
   logic [CW-1:0] limit;

   assign limit   = stretch_req ? FULL_AT : LAST_AT;
   assign mid_evt = act_q && (cnt_q == MID_AT);
   assign end_evt = act_q && (cnt_q == limit);
   assign active  = act_q;
   assign cnt     = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else if (!run) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else if (!act_q) begin
         act_q <= 1'b1;
         cnt_q <= '0;
      end else if (end_evt) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   // R2: count never passes the stretched bit length
   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL_AT);

   // R2: the bit counter wraps to zero after a bit ends
   p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (end_evt && run) |=> (cnt_q == '0));

   // R8: the extra cycle is reached only for a requested stretch
   p_stretch_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && cnt_q == LAST_AT && !stretch_req && run) |=> (cnt_q == '0));

endmodule

// File: rtl/lm_bit_source.sv
module lm_bit_source #(
   parameter int WORD_BITS = 64,
   parameter bit LSB_FIRST = 1'b0,
   localparam int IW = $clog2(WORD_BITS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic                 start,
   input  logic                 advance,
   input  logic [WORD_BITS-1:0] word_in,
   input  logic [WORD_BITS-1:0] mask_in,
   input  logic                 stretch_en,
   output logic                 first_bit,
   output logic                 cur_bit,
   output logic                 next_bit,
   output logic                 stretch_req
);

   initial begin
      assert (WORD_BITS >= 2)
         else $error("lm_bit_source: WORD_BITS must be at least 2");
   end

   localparam logic [IW-1:0] LAST_IDX = IW'(WORD_BITS - 1);

   logic [WORD_BITS-1:0] sreg_q;
   logic [WORD_BITS-1:0] shifted;
   logic [IW-1:0]        idx_q;
   logic [IW-1:0]        pos;
   logic                 in_word_next;
   logic                 last;

   assign last = (idx_q == LAST_IDX);

   generate
      if (LSB_FIRST) begin : g_lsb
         assign shifted      = sreg_q >> 1;
         assign cur_bit      = sreg_q[0];
         assign in_word_next = sreg_q[1];
         assign first_bit    = word_in[0];
         assign pos          = idx_q;
      end else begin : g_msb
         assign shifted      = sreg_q << 1;
         assign cur_bit      = sreg_q[WORD_BITS-1];
         assign in_word_next = sreg_q[WORD_BITS-2];
         assign first_bit    = word_in[WORD_BITS-1];
         assign pos          = LAST_IDX - idx_q;
      end
   endgenerate

   assign next_bit    = last ? first_bit : in_word_next;
   assign stretch_req = stretch_en && mask_in[pos];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '0;
         idx_q  <= '0;
      end else if (!run) begin
         idx_q  <= '0;
      end else if (start) begin
         sreg_q <= word_in;
         idx_q  <= '0;
      end else if (advance) begin
         if (last) begin
            sreg_q <= word_in;
            idx_q  <= '0;
         end else begin
            sreg_q <= shifted;
            idx_q  <= idx_q + IW'(1);
         end
      end
   end

   // R5: a word wrap reloads the register from the word input
   p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && advance && last) |=> (sreg_q == $past(word_in)));

   // R5: a fresh start always begins at the first position of the word
   p_start_head_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && start) |=> (cur_bit == $past(first_bit)));

endmodule

// File: rtl/lm_line_coder.sv
module lm_line_coder
   import lm_enc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic start,
   input  logic mid_evt,
   input  logic end_evt,
   input  logic mode,
   input  logic first_bit,
   input  logic cur_bit,
   input  logic next_bit,
   output logic mod_out
);

   line_code_e code;
   logic       line_q;
   logic       line_d;

   assign code = line_code_e'(mode);

   always_comb begin
      if (!run)         line_d = 1'b0;
      else if (start)   line_d = bound_level(code, first_bit, line_q);
      else if (end_evt) line_d = bound_level(code, next_bit, line_q);
      else if (mid_evt) line_d = mid_level(code, cur_bit, line_q);
      else              line_d = line_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= 1'b0;
      else        line_q <= line_d;
   end

   assign mod_out = line_q;

   // R4: biphase always toggles at a bit boundary
   p_biphase_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && end_evt && mode) |=> (line_q != $past(line_q)));

   // R4: a biphase 1 bit holds its level across the middle
   p_biphase_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && mid_evt && mode && cur_bit) |=> $stable(line_q));

endmodule

// File: rtl/carrier_manchester_tx.sv
module carrier_manchester_tx #(
   parameter int BIT_CYCLES = 64,
   parameter int WORD_BITS  = 64,
   parameter bit LSB_FIRST  = 1'b0,
   localparam int CW = $clog2(BIT_CYCLES + 1)
) (
   input  logic                 carrier_clk,
   input  logic                 rst_n,
   input  logic                 carrier_ok,
   input  logic                 code_sel,
   input  logic [WORD_BITS-1:0] tx_word,
   input  logic [WORD_BITS-1:0] stretch_mask,
   input  logic                 stretch_test,
   output logic                 mod_out
);

   logic          active;
   logic          mid_evt;
   logic          end_evt;
   logic [CW-1:0] cnt;
   logic          start;
   logic          first_bit;
   logic          cur_bit;
   logic          next_bit;
   logic          stretch_req;

   assign start = carrier_ok && !active;

   lm_bit_timer #(.BIT_CYCLES(BIT_CYCLES)) u_timer (
      .clk         (carrier_clk),
      .rst_n       (rst_n),
      .run         (carrier_ok),
      .stretch_req (stretch_req),
      .active      (active),
      .mid_evt     (mid_evt),
      .end_evt     (end_evt),
      .cnt         (cnt)
   );

   lm_bit_source #(.WORD_BITS(WORD_BITS), .LSB_FIRST(LSB_FIRST)) u_source (
      .clk         (carrier_clk),
      .rst_n       (rst_n),
      .run         (carrier_ok),
      .start       (start),
      .advance     (end_evt),
      .word_in     (tx_word),
      .mask_in     (stretch_mask),
      .stretch_en  (stretch_test),
      .first_bit   (first_bit),
      .cur_bit     (cur_bit),
      .next_bit    (next_bit),
      .stretch_req (stretch_req)
   );

   lm_line_coder u_coder (
      .clk       (carrier_clk),
      .rst_n     (rst_n),
      .run       (carrier_ok),
      .start     (start),
      .mid_evt   (mid_evt),
      .end_evt   (end_evt),
      .mode      (code_sel),
      .first_bit (first_bit),
      .cur_bit   (cur_bit),
      .next_bit  (next_bit),
      .mod_out   (mod_out)
   );

   // R1, R7: losing the carrier forces the line low on the next edge
   p_idle_low_r1: assert property (@(posedge carrier_clk) disable iff (!rst_n)
      !carrier_ok |=> !mod_out);

   // R3: Manchester always toggles in the middle of a bit
   p_manch_mid_r3: assert property (@(posedge carrier_clk) disable iff (!rst_n)
      (carrier_ok && mid_evt && !code_sel) |=> (mod_out != $past(mod_out)));

   // R2: the line holds between the middle and boundary events
   p_hold_r2: assert property (@(posedge carrier_clk) disable iff (!rst_n)
      (carrier_ok && active && !mid_evt && !end_evt) |=> $stable(mod_out));

   // R6: a biphase transmission opens with a high level
   p_first_level_r6: assert property (@(posedge carrier_clk) disable iff (!rst_n)
      (start && code_sel) |=> mod_out);

   // R9: with the test mode off, the count never reaches the stretched length
   p_no_stretch_r9: assert property (@(posedge carrier_clk) disable iff (!rst_n)
      (!stretch_test && $past(!stretch_test)) |-> (cnt != CW'(BIT_CYCLES)));

endmodule

// File: tb/sim_carrier_manchester_tx.sv
module sim_carrier_manchester_tx;

   localparam int HALF = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        carrier_ok = 1'b0;
   logic        code_sel = 1'b0;
   logic [63:0] tx_word = '0;
   logic [63:0] stretch_mask = '0;
   logic        stretch_test = 1'b0;
   logic        mod_out;

   int    n_checks = 0;
   int    n_fails  = 0;
   logic  lvl_q[$];
   string cur_tag = "R1";
   logic  carrier_q = 1'b0;
   int    sample_no = 0;
   bit    done = 1'b0;

   always #5 clk = ~clk;

   carrier_manchester_tx u0 (
      .carrier_clk  (clk),
      .rst_n        (rst_n),
      .carrier_ok   (carrier_ok),
      .code_sel     (code_sel),
      .tx_word      (tx_word),
      .stretch_mask (stretch_mask),
      .stretch_test (stretch_test),
      .mod_out      (mod_out)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   always @(posedge clk) carrier_q <= carrier_ok;

   // Monitor: pop one expected level per carrier cycle of transmission
   always @(negedge clk) begin
      if (carrier_q) begin
         sample_no++;
         if (lvl_q.size() == 0) begin
            check(1'b0, cur_tag, "unexpected extra sample", sample_no, 0);
         end else begin
            logic e;
            e = lvl_q.pop_front();
            check(mod_out === e, cur_tag, $sformatf("mod_out at sample %0d", sample_no),
                  longint'(mod_out), longint'(e));
         end
      end
   end

   // Driver: build the expected waveform from the requirements, then transmit
   task automatic run_tx(input logic [63:0] wa, input logic [63:0] wb, input int switch_at,
                         input logic [63:0] mask, input logic sten, input logic bph,
                         input int nsamp, input string tag);
      logic lvl;
      int   pushed;
      int   k;
      lvl = 1'b0;
      pushed = 0;
      k = 0;
      while (pushed < nsamp) begin
         logic [63:0] w;
         int   j;
         logic b, st, f, s;
         w  = (k < 64) ? wa : wb;
         j  = k % 64;
         b  = w[63-j];
         st = sten & mask[63-j];
         f  = bph ? ~lvl : b;
         s  = bph ? (b ? f : ~f) : ~f;
         for (int c = 0; c < HALF; c++)
            if (pushed < nsamp) begin lvl_q.push_back(f); pushed++; end
         for (int c = 0; c < HALF + int'(st); c++)
            if (pushed < nsamp) begin lvl_q.push_back(s); pushed++; end
         lvl = s;
         k++;
      end
      @(negedge clk);
      cur_tag      = tag;
      sample_no    = 0;
      tx_word      = wa;
      stretch_mask = mask;
      stretch_test = sten;
      code_sel     = bph;
      carrier_ok   = 1'b1;
      for (int n = 1; n <= nsamp; n++) begin
         @(negedge clk);
         if (n == switch_at) tx_word = wb;
      end
      carrier_ok = 1'b0;
      @(negedge clk);
      check(mod_out === 1'b0, "R7", "line after carrier loss", longint'(mod_out), 0);
      @(negedge clk);
      check(mod_out === 1'b0, "R1", "idle line", longint'(mod_out), 0);
      check(lvl_q.size() == 0, tag, "expected samples left over", lvl_q.size(), 0);
      lvl_q.delete();
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [63:0] wa, wb;
      wa = 64'hA5C3_0F96_1E2D_7B48;
      wb = 64'h3C69_D2B4_8E17_F05A;

      // R1: line low during and after reset while the carrier is absent
      repeat (3) @(negedge clk);
      check(mod_out === 1'b0, "R1", "line during reset", longint'(mod_out), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(mod_out === 1'b0, "R1", "line after reset", longint'(mod_out), 0);

      // R2 R3 R5 R6: Manchester across a word wrap
      run_tx(wa, wa, 0, '0, 1'b0, 1'b0, 66*64, "R2 R3 R5 R6 manchester");
      // R2 R4 R5 R6: biphase across a word wrap
      run_tx(wa, wa, 0, '0, 1'b0, 1'b1, 66*64, "R2 R4 R5 R6 biphase");
      // R8: stretched bits in Manchester, including the last bit before the wrap
      run_tx(wa, wa, 0, 64'h8000_0000_0000_0011, 1'b1, 1'b0, 66*64 + 8, "R8 manchester stretch");
      // R8: stretched bits in biphase
      run_tx(wb, wb, 0, 64'h0102_0408_1020_4081, 1'b1, 1'b1, 66*64 + 8, "R8 biphase stretch");
      // R9: mask ignored when the test mode is off
      run_tx(wa, wa, 0, '1, 1'b0, 1'b0, 20*64, "R9 mask ignored");
      // R5: word input changed mid-word takes effect only at the wrap
      run_tx(wa, wb, 10*64, '0, 1'b0, 1'b0, 130*64, "R5 word reload");
      // R7: carrier lost mid-bit, then a fresh start from the MSB
      run_tx(wb, wb, 0, '0, 1'b0, 1'b0, 5*64 + 17, "R7 mid-bit loss");
      run_tx(wb, wb, 0, '0, 1'b0, 1'b0, 6*64, "R7 R6 restart");
      // R4: all-zero word toggles every half bit in biphase
      run_tx('0, '0, 0, '0, 1'b0, 1'b1, 8*64, "R4 zeros biphase");
      // R3: all-one word in Manchester
      run_tx('1, '1, 0, '0, 1'b0, 1'b0, 8*64, "R3 ones manchester");

      summary();
   end

endmodule